// File: doc/BRIEF.md
# Two-Channel Ring-Oscillator Timestamp Decoder

This block converts raw hit captures from a ring-oscillator time-to-digital converter into binary timestamps. Each of two hit channels has external latches that freeze, at the moment of the hit, the tap vector of a shared ring oscillator and two Gray-coded samples of a shared coarse counter. The ring holds one inversion, so its N_TAPS taps pass through 2*N_TAPS distinct patterns per oscillation: first ones spread upward from tap 0, then zeros do. The block decodes that pattern into a fine bin, filters single-tap bubbles, picks the coarse sample that was stable at the hit, and joins the two into one timestamp.

Each channel's hit strobe arrives asynchronously. The block synchronises it and registers the decoded timestamp once the latched buses have settled. Results stay pending until the channel is read. When both channels hold pending results, the block also reports the signed difference of the two timestamps in bins.

Top module: `ro_tdc_stamp`

## Requirements
- R1: A clean tap pattern of phase k (0..2*N_TAPS-1) decodes to fine bin k. For k < N_TAPS, taps [k-1:0] are 1 and all other taps are 0. For k >= N_TAPS, taps [k-N_TAPS-1:0] are 0 and all other taps are 1.
- R2: Each tap is replaced by the majority of itself and its two ring neighbours. The neighbour below tap 0 is the inverted top tap, and the neighbour above the top tap is the inverted tap 0. A single flipped tap that is not adjacent to the transition is therefore corrected, and a clean pattern passes through unchanged.
- R3: When the fine MSB is 0, the coarse value comes from the late sample, taken half an oscillator period after the hit. When the fine MSB is 1, it comes from the early sample, taken at the hit. The selected Gray value is converted to binary.
- R4: The timestamp equals coarse*2*N_TAPS + fine. Channel c occupies ts_o[c*TS_W +: TS_W], where TS_W = COARSE_W + log2(2*N_TAPS).
- R5: After hit_i[c] rises, valid_o[c] is high for exactly one cycle, on the third rising clock edge. The timestamp is held until the next capture.
- R6: pend_o[c] rises together with valid_o[c]. It clears on the edge at which rd_i[c] is high, unless a new capture happens on that same edge.
- R7: A capture while pend_o[c] is set and rd_i[c] is low sets ovf_o[c]. The flag stays set until reset, and the newer timestamp replaces the older one.
- R8: One edge after both channels are pending, diff_valid_o is 1 and diff_o equals ts(ch1) - ts(ch0) in two's complement, TS_W+1 bits wide. One edge after either channel stops pending, diff_valid_o is 0.
- R9: Reset is synchronous and active high. It clears all timestamps, valid_o, pend_o, ovf_o, diff_o and diff_valid_o.
- R10: A hit on one channel leaves the other channel's timestamp, pending flag and valid_o unchanged.
- R11: A hit strobe held high gives one capture only. A new capture needs the strobe to go low and rise again, and both the low and the high phase must last at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 2 | Asynchronous hit strobe, one per channel |
| rd_i | input | 2 | Read acknowledge per channel, clears pending |
| taps_i | input | 2*N_TAPS | Latched tap vector per channel |
| crs_early_i | input | 2*COARSE_W | Gray coarse sample taken at the hit, per channel |
| crs_late_i | input | 2*COARSE_W | Gray coarse sample taken half a period later, per channel |
| ts_o | output | 2*TS_W | Binary timestamp per channel |
| valid_o | output | 2 | One-cycle pulse for a new timestamp |
| pend_o | output | 2 | Timestamp not yet read |
| ovf_o | output | 2 | Sticky flag: a capture overwrote an unread result |
| diff_o | output | TS_W+1 | Signed difference ts(ch1) - ts(ch0) |
| diff_valid_o | output | 1 | diff_o is based on two pending results |

## Verification
The bench builds the block with N_TAPS = 16 and COARSE_W = 4, so a timestamp spans 9 bits. This small coarse range puts the largest timestamp (511) and coarse wrap-around within a few vectors. It also reaches differences of both signs, including large negative ones near the range limit. Each vector makes the unused coarse sample deliberately one count off. A wrong pick between the early and late samples therefore changes the timestamp, and the vectors cover all four edge phases 0, 15, 16 and 31.

// File: rtl/rotdc_pkg.sv
package rotdc_pkg;

    // Which latched coarse sample supplies the timestamp MSBs.
    typedef enum logic {
        CRS_LATE  = 1'b0,
        CRS_EARLY = 1'b1
    } crs_pick_e;

    // Two-out-of-three vote used by the tap bubble filter.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // True when a tap vector is a clean pattern of the inverting ring.
    function automatic logic ring_clean(input logic [63:0] v, input int unsigned n);
        logic [63:0] f;
        logic [63:0] m;
        m = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        f = (v ^ {64{v[n-1]}}) & m;
        return ((f & (f + 64'd1)) & m) == 64'd0;
    endfunction

endpackage

// File: rtl/rotdc_fine_dec.sv
module rotdc_fine_dec
    import rotdc_pkg::*;
#(
    parameter int N_TAPS = 16,
    localparam int FINE_W = $clog2(2 * N_TAPS)
) (
    input  logic [N_TAPS-1:0] taps_i,
    output logic [N_TAPS-1:0] clean_o,
    output logic [FINE_W-1:0] fine_o
);

    localparam int POS_W = FINE_W - 1;

    // Ring-extended vector: inverted wrap neighbours on both ends.
    logic [N_TAPS+1:0] ext;
    assign ext = {~taps_i[0], taps_i, ~taps_i[N_TAPS-1]};

    for (genvar i = 0; i < N_TAPS; i++) begin : g_vote
        assign clean_o[i] = maj3(ext[i], ext[i+1], ext[i+2]);
    end

    // Fold the second half-period onto the first, then find the first zero.
    logic [N_TAPS-1:0] folded;
    logic [POS_W-1:0]  pos;
    logic              found;

    always_comb begin
        folded = clean_o ^ {N_TAPS{clean_o[N_TAPS-1]}};
        pos    = '0;
        found  = 1'b0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (!found && !folded[i]) begin
                pos   = POS_W'(i);
                found = 1'b1;
            end
        end
    end

    assign fine_o = {clean_o[N_TAPS-1], pos};

endmodule

// File: rtl/rotdc_coarse_sel.sv
module rotdc_coarse_sel
    import rotdc_pkg::*;
#(
    parameter int COARSE_W = 12
) (
    input  logic [COARSE_W-1:0] early_gray_i,
    input  logic [COARSE_W-1:0] late_gray_i,
    input  crs_pick_e           pick_i,
    output logic [COARSE_W-1:0] bin_o
);

    logic [COARSE_W-1:0] gsel;
    assign gsel = (pick_i == CRS_EARLY) ? early_gray_i : late_gray_i;

    // Binary bit i is the XOR of all Gray bits at or above i.
    for (genvar i = 0; i < COARSE_W; i++) begin : g_g2b
        assign bin_o[i] = ^gsel[COARSE_W-1:i];
    end

endmodule

// File: rtl/rotdc_channel.sv
module rotdc_channel
    import rotdc_pkg::*;
#(
    parameter int N_TAPS   = 16,
    parameter int COARSE_W = 12,
    localparam int FINE_W  = $clog2(2 * N_TAPS),
    localparam int TS_W    = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_i,
    input  logic                rd_i,
    input  logic [N_TAPS-1:0]   taps_i,
    input  logic [COARSE_W-1:0] crs_early_i,
    input  logic [COARSE_W-1:0] crs_late_i,
    output logic [TS_W-1:0]     ts_o,
    output logic                valid_o,
    output logic                pend_o,
    output logic                ovf_o
);

    logic [2:0]          sync_q;
    logic                rise;
    logic [N_TAPS-1:0]   clean;
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse_bin;
    crs_pick_e           pick;

    logic [TS_W-1:0] ts_q;
    logic            valid_q;
    logic            pend_q;
    logic            ovf_q;

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], hit_i};
    end
    assign rise = sync_q[1] & ~sync_q[2];

    rotdc_fine_dec #(.N_TAPS(N_TAPS)) u_fine (
        .taps_i  (taps_i),
        .clean_o (clean),
        .fine_o  (fine)
    );

    assign pick = crs_pick_e'(fine[FINE_W-1]);

    rotdc_coarse_sel #(.COARSE_W(COARSE_W)) u_crs (
        .early_gray_i (crs_early_i),
        .late_gray_i  (crs_late_i),
        .pick_i       (pick),
        .bin_o        (coarse_bin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q    <= '0;
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            valid_q <= rise;
            if (rise) begin
                ts_q   <= {coarse_bin, fine};
                pend_q <= 1'b1;
                if (pend_q && !rd_i) ovf_q <= 1'b1;
            end else if (rd_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign ts_o    = ts_q;
    assign valid_o = valid_q;
    assign pend_o  = pend_q;
    assign ovf_o   = ovf_q;

    assert_valid_after_sync_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_q[1]) |=> valid_q);
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    assert_pend_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> pend_q);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_clean_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        ring_clean(64'(taps_i), N_TAPS) |-> (clean == taps_i));

endmodule

// File: rtl/ro_tdc_stamp.sv
module ro_tdc_stamp
    import rotdc_pkg::*;
#(
    parameter int N_TAPS   = 16,
    parameter int COARSE_W = 12,
    localparam int N_CH    = 2,
    localparam int FINE_W  = $clog2(2 * N_TAPS),
    localparam int TS_W    = COARSE_W + FINE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CH-1:0]            hit_i,
    input  logic [N_CH-1:0]            rd_i,
    input  logic [N_CH*N_TAPS-1:0]     taps_i,
    input  logic [N_CH*COARSE_W-1:0]   crs_early_i,
    input  logic [N_CH*COARSE_W-1:0]   crs_late_i,
    output logic [N_CH*TS_W-1:0]       ts_o,
    output logic [N_CH-1:0]            valid_o,
    output logic [N_CH-1:0]            pend_o,
    output logic [N_CH-1:0]            ovf_o,
    output logic signed [TS_W:0]       diff_o,
    output logic                       diff_valid_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        rotdc_channel #(.N_TAPS(N_TAPS), .COARSE_W(COARSE_W)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .hit_i       (hit_i[c]),
            .rd_i        (rd_i[c]),
            .taps_i      (taps_i[c*N_TAPS +: N_TAPS]),
            .crs_early_i (crs_early_i[c*COARSE_W +: COARSE_W]),
            .crs_late_i  (crs_late_i[c*COARSE_W +: COARSE_W]),
            .ts_o        (ts_o[c*TS_W +: TS_W]),
            .valid_o     (valid_o[c]),
            .pend_o      (pend_o[c]),
            .ovf_o       (ovf_o[c])
        );
    end

    logic signed [TS_W:0] diff_q;
    logic                 diff_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q       <= '0;
            diff_valid_q <= 1'b0;
        end else begin
            diff_valid_q <= &pend_o;
            diff_q       <= $signed({1'b0, ts_o[TS_W +: TS_W]}) - $signed({1'b0, ts_o[0 +: TS_W]});
        end
    end

    assign diff_o       = diff_q;
    assign diff_valid_o = diff_valid_q;

    assert_diff_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !(&pend_o) |=> !diff_valid_o);

endmodule

// File: tb/ro_tdc_stamp_bench.sv
`timescale 1ns/1ps
module ro_tdc_stamp_bench;

    localparam int NT = 16;
    localparam int CW = 4;
    localparam int TW = CW + 5;
    localparam int NV = 10;

    // Entry: {ch(1), phase(5), bubble_en(1), bubble_bit(4), coarse(4)}
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 5'd0,  1'b0, 4'd0,  4'd0},
        {1'b1, 5'd31, 1'b0, 4'd0,  4'd15},
        {1'b0, 5'd16, 1'b0, 4'd0,  4'd5},
        {1'b1, 5'd15, 1'b0, 4'd0,  4'd7},
        {1'b0, 5'd10, 1'b1, 4'd4,  4'd3},
        {1'b1, 5'd20, 1'b1, 4'd9,  4'd9},
        {1'b0, 5'd3,  1'b1, 4'd12, 4'd12},
        {1'b1, 5'd29, 1'b1, 4'd6,  4'd1},
        {1'b0, 5'd1,  1'b0, 4'd0,  4'd15},
        {1'b1, 5'd8,  1'b0, 4'd0,  4'd0}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            hit_i = '0;
    logic [1:0]            rd_i = '0;
    logic [2*NT-1:0]       taps_i = '0;
    logic [2*CW-1:0]       crs_early_i = '0;
    logic [2*CW-1:0]       crs_late_i = '0;
    logic [2*TW-1:0]       ts_o;
    logic [1:0]            valid_o;
    logic [1:0]            pend_o;
    logic [1:0]            ovf_o;
    logic signed [TW:0]    diff_o;
    logic                  diff_valid_o;

    int checks = 0;
    int errors = 0;
    int expv [2] = '{0, 0};

    always #10 clk = ~clk;

    ro_tdc_stamp #(.N_TAPS(NT), .COARSE_W(CW)) u_ro_tdc_stamp (
        .clk(clk), .rst(rst), .hit_i(hit_i), .rd_i(rd_i), .taps_i(taps_i),
        .crs_early_i(crs_early_i), .crs_late_i(crs_late_i), .ts_o(ts_o),
        .valid_o(valid_o), .pend_o(pend_o), .ovf_o(ovf_o),
        .diff_o(diff_o), .diff_valid_o(diff_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] thermo(input int k);
        logic [NT-1:0] t;
        for (int i = 0; i < NT; i++)
            t[i] = (k < NT) ? (i < k) : !(i < k - NT);
        return t;
    endfunction

    function automatic logic [CW-1:0] gray(input int b);
        logic [CW-1:0] v;
        v = CW'(b);
        return v ^ (v >> 1);
    endfunction

    // Drive one channel's latched buses for phase k, coarse c; wrong sample is off by one.
    task automatic load(input int ch, input int k, input bit ben, input int bub, input int c);
        logic [NT-1:0] t;
        t = thermo(k);
        if (ben) t[bub] = ~t[bub];
        taps_i[ch*NT +: NT] = t;
        crs_early_i[ch*CW +: CW] = (k >= NT) ? gray(c) : gray(c + 1);
        crs_late_i[ch*CW +: CW]  = (k >= NT) ? gray(c + 1) : gray(c);
    endtask

    // Raise hit and return just after the edge that should show valid.
    task automatic fire(input int ch);
        @(negedge clk);
        hit_i[ch] = 1'b1;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic drop(input int ch);
        @(negedge clk);
        hit_i[ch] = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic read(input logic [1:0] m);
        @(negedge clk);
        rd_i = m;
        @(posedge clk);
        #1;
        rd_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(valid_o == 0, "R9 valid after reset", int'(valid_o), 0);
        chk(pend_o == 0 && ovf_o == 0, "R9 pend/ovf after reset", int'({pend_o, ovf_o}), 0);
        chk(ts_o == 0 && diff_valid_o == 0, "R9 ts/diff after reset", int'(ts_o), 0);

        // Vector walk: R1 R2 R3 R4 R5 R6 R8 R10
        for (int n = 0; n < NV; n++) begin
            int ch, k, bub, c, oth;
            bit ben;
            ch  = int'(VEC[n][14]);
            k   = int'(VEC[n][13:9]);
            ben = VEC[n][8];
            bub = int'(VEC[n][7:4]);
            c   = int'(VEC[n][3:0]);
            oth = 1 - ch;
            load(ch, k, ben, bub, c);
            expv[ch] = c * 32 + k;
            fire(ch);
            chk(valid_o[ch] == 1'b1, "R5 valid on third edge", int'(valid_o[ch]), 1);
            chk(int'(ts_o[ch*TW +: TW]) == expv[ch],
                ben ? "R2 bubble-corrected timestamp" : "R1 R3 R4 timestamp",
                int'(ts_o[ch*TW +: TW]), expv[ch]);
            chk(pend_o[ch] == 1'b1, "R6 pending with valid", int'(pend_o[ch]), 1);
            chk(int'(pend_o[oth]) == ch && valid_o[oth] == 1'b0 &&
                int'(ts_o[oth*TW +: TW]) == expv[oth],
                "R10 other channel untouched", int'(ts_o[oth*TW +: TW]), expv[oth]);
            @(posedge clk);
            #1;
            chk(valid_o[ch] == 1'b0, "R5 valid one cycle", int'(valid_o[ch]), 0);
            if (ch == 1) begin
                chk(diff_valid_o == 1'b1, "R8 diff valid", int'(diff_valid_o), 1);
                chk(int'(diff_o) == expv[1] - expv[0], "R8 diff value",
                    int'(diff_o), expv[1] - expv[0]);
            end
            drop(ch);
            if (ch == 1) begin
                read(2'b11);
                chk(pend_o == 2'b00, "R6 read clears pending", int'(pend_o), 0);
                @(posedge clk);
                #1;
                chk(diff_valid_o == 1'b0, "R8 diff valid drops", int'(diff_valid_o), 0);
            end
        end

        // R11: held strobe captures once
        begin
            int pulses;
            pulses = 0;
            load(0, 7, 1'b0, 0, 2);
            @(negedge clk);
            hit_i[0] = 1'b1;
            for (int i = 0; i < 16; i++) begin
                @(posedge clk);
                #1;
                if (valid_o[0]) pulses++;
            end
            chk(pulses == 1, "R11 one capture per rising strobe", pulses, 1);
            drop(0);
            read(2'b01);
        end

        // R7: second capture before read sets sticky overflow
        load(1, 5, 1'b0, 0, 4);
        fire(1);
        chk(ovf_o[1] == 1'b0, "R7 no overflow on first capture", int'(ovf_o[1]), 0);
        drop(1);
        load(1, 22, 1'b0, 0, 2);
        fire(1);
        chk(ovf_o[1] == 1'b1, "R7 overflow set", int'(ovf_o[1]), 1);
        chk(int'(ts_o[TW +: TW]) == 86, "R7 newer timestamp kept", int'(ts_o[TW +: TW]), 86);
        chk(ovf_o[0] == 1'b0, "R7 R10 other channel no overflow", int'(ovf_o[0]), 0);
        drop(1);
        read(2'b10);
        repeat (3) @(posedge clk);
        #1;
        chk(ovf_o[1] == 1'b1, "R7 overflow sticky after read", int'(ovf_o[1]), 1);

        // R9: reset again clears sticky state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk(ovf_o == 2'b00 && pend_o == 2'b00, "R9 reset clears flags",
            int'({ovf_o, pend_o}), 0);
        chk(ts_o == 0, "R9 reset clears timestamps", int'(ts_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule